// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Execution Unit

This unit executes the second byte of a two-byte prefixed instruction group of an 8-bit processor. It accepts the opcode byte on a valid/ready stream and splits it into an operation class, a sub-operation or bit index, and an operand selector. It then performs one of eight shift kinds (one a nibble swap), a bit test, a bit clear or a bit set on an 8-bit operand. It returns the result byte, the four flags and a register write-back enable on a second valid/ready stream. The register file sits outside. The unit drives the register read address straight from the incoming opcode and takes the operand value in the same cycle. A memory operand (the byte addressed by the pointer pair, held outside the unit) is reached through a read-modify-write port that also uses a valid/ready handshake.

Back-pressure rules: `op_ready` is high only while the unit is idle. An opcode is taken on a cycle with `op_valid && op_ready`. The result stays on `res_*` with `res_valid` high, and does not change, until a cycle with `res_ready` high. Only after that does `op_ready` return. A memory access completes on a cycle with `mem_valid && mem_ready`. Each cycle that `mem_ready` is held low adds one cycle to the instruction.

With the default `MCYC = 4` clocks per machine cycle, a register operation takes 8 cycles, a bit test on memory takes 12, and a memory read-modify-write takes 16. The count includes the accepting cycle.

Top module: `pfx_bitops`

## Requirements
- R1: After reset, `op_ready` is 1, `res_valid` is 0 and `mem_valid` is 0.
- R2: Opcode bits 2..0 select the operand: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory, 7=A. `rf_sel` equals `op_code[2:0]` while an opcode is offered, and `res_sel` returns the selector with the result.
- R3: When opcode bits 7..6 are 00, bits 5..3 choose the shift kind: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left arithmetic, 5 shift right arithmetic, 6 swap nibbles, 7 shift right logical.
- R4: Flags are `res_flags` = {Z,N,H,C} in bits 3..0, and `flg_in` uses the same layout. For any shift or rotate, C is the bit shifted out, N and H are 0, and Z is 1 exactly when the result is 0.
- R5: Shift right arithmetic keeps the old bit 7. The through-carry rotates move the incoming C into the vacated bit.
- R6: Swap exchanges the two nibbles and clears C, N and H. Z follows the result.
- R7: Bits 7..6 = 01 test bit n (n = bits 5..3). Z = inverse of that bit, N = 0, H = 1, C is unchanged. `res_data` is the unmodified operand and `res_wb` is 0.
- R8: Bits 7..6 = 10 clear bit n and 11 set bit n. All four flags equal `flg_in`.
- R9: With no memory stall, `res_valid` first shows 7 clock edges after the accepting edge for register operands. For a memory bit test it shows after 11 edges, with one read and no write. For any other memory operation it shows after 15 edges, with one read followed by one write of the result byte. `res_wb` is 0 for every memory operand and 1 for register shift, clear and set.
- R10: Each cycle in which `mem_valid` is high and `mem_ready` is low delays the result by one cycle. Read data is taken on the completing cycle.
- R11: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_flags` hold, and `op_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode byte offered |
| op_ready | output | 1 | Unit idle, opcode will be taken |
| op_code | input | 8 | Second opcode byte |
| rf_sel | output | 3 | Register-file read address, from `op_code[2:0]` |
| rf_rdata | input | 8 | Register operand value for `rf_sel`, same cycle |
| flg_in | input | 4 | Current flags {Z,N,H,C}, sampled with the opcode |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write of `mem_wdata`, 0 = read |
| mem_wdata | output | 8 | Modified byte to store |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` on a read |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 8 | Result byte |
| res_flags | output | 4 | New flags {Z,N,H,C} |
| res_wb | output | 1 | Write `res_data` into register `res_sel` |
| res_sel | output | 3 | Operand selector of the finished instruction |

## Verification
Several properties are checked on every cycle. A held result must not change under back-pressure, and the unit never offers a result while it also accepts an opcode. A write-back never targets the memory selector, and every finished shift-class result carries Z matching a zero byte with N and H clear. A memory read must also complete only once per instruction. The bench scenarios show the rest: the exact value of each shift kind and bit operation, carry-in and carry-out behaviour, the 8/12/16-cycle counts, the stretch added by memory stalls, and the absence of a write for a memory bit test.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  localparam int DW = 8;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_TEST  = 2'b01,
    CLS_CLR   = 2'b10,
    CLS_SET   = 2'b11
  } cls_e;

  typedef enum logic [2:0] {
    SH_RLC  = 3'd0,
    SH_RRC  = 3'd1,
    SH_RL   = 3'd2,
    SH_RR   = 3'd3,
    SH_SLA  = 3'd4,
    SH_SRA  = 3'd5,
    SH_SWAP = 3'd6,
    SH_SRL  = 3'd7
  } shk_e;

  localparam logic [2:0] SEL_MEM = 3'd6;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  // Field order matches the opcode byte: class, sub-op/bit index, operand.
  typedef struct packed {
    cls_e       cls;
    logic [2:0] sub;
    logic [2:0] sel;
  } dec_t;

endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
  import pfx_pkg::*;
(
  input  logic [7:0] code,
  output dec_t       dec,
  output logic       is_mem,
  output logic       needs_wr
);
  always_comb begin
    dec      = dec_t'(code);
    is_mem   = (dec.sel == SEL_MEM);
    needs_wr = is_mem && (dec.cls != CLS_TEST);
  end
endmodule

// File: rtl/pfx_alu.sv
module pfx_alu
  import pfx_pkg::*;
#(
  parameter int W = 8
) (
  input  cls_e             cls,
  input  logic [2:0]       sub,
  input  logic [W-1:0]     opnd,
  input  flags_t           fin,
  output logic [W-1:0]     res,
  output flags_t           fout
);
  localparam int IW = $clog2(W);
  localparam int HW = W / 2;

  logic [W-1:0] mask;
  logic [IW-1:0] idx;
  logic          cout;
  logic [W-1:0]  shres;

  assign idx = sub[IW-1:0];

  for (genvar gi = 0; gi < W; gi++) begin : g_mask
    assign mask[gi] = (idx == IW'(gi));
  end

  always_comb begin
    shres = opnd;
    cout  = 1'b0;
    case (shk_e'(sub))
      SH_RLC:  begin shres = {opnd[W-2:0], opnd[W-1]}; cout = opnd[W-1]; end
      SH_RRC:  begin shres = {opnd[0], opnd[W-1:1]};   cout = opnd[0];   end
      SH_RL:   begin shres = {opnd[W-2:0], fin.c};     cout = opnd[W-1]; end
      SH_RR:   begin shres = {fin.c, opnd[W-1:1]};     cout = opnd[0];   end
      SH_SLA:  begin shres = {opnd[W-2:0], 1'b0};      cout = opnd[W-1]; end
      SH_SRA:  begin shres = {opnd[W-1], opnd[W-1:1]}; cout = opnd[0];   end
      SH_SWAP: begin shres = {opnd[HW-1:0], opnd[W-1:HW]}; cout = 1'b0; end
      default: begin shres = {1'b0, opnd[W-1:1]};      cout = opnd[0];   end
    endcase
  end

  always_comb begin
    res  = opnd;
    fout = fin;
    case (cls)
      CLS_SHIFT: begin
        res    = shres;
        fout.z = (shres == '0);
        fout.n = 1'b0;
        fout.h = 1'b0;
        fout.c = cout;
      end
      CLS_TEST: begin
        fout.z = ~|(opnd & mask);
        fout.n = 1'b0;
        fout.h = 1'b1;
      end
      CLS_CLR: res = opnd & ~mask;
      default: res = opnd | mask;
    endcase
  end
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq #(
  parameter int MCYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_mem,
  input  logic needs_wr,
  input  logic mem_ready,
  input  logic res_ready,
  output logic idle,
  output logic mem_valid,
  output logic mem_write,
  output logic rd_fire,
  output logic res_valid
);
  localparam int LAT_REG = 2 * MCYC;
  localparam int LAT_MRD = 3 * MCYC;
  localparam int LAT_RMW = 4 * MCYC;
  localparam int RD_AT   = 2 * MCYC - 2;
  localparam int WR_AT   = 3 * MCYC - 2;
  localparam int CW      = $clog2(LAT_RMW);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic          mem_q;
  logic          wr_q;
  logic          at_rd;
  logic          at_wr;
  logic          stall;

  assign at_rd     = (st_q == S_RUN) && mem_q && (cnt_q == CW'(RD_AT));
  assign at_wr     = (st_q == S_RUN) && wr_q && (cnt_q == CW'(WR_AT));
  assign mem_valid = at_rd || at_wr;
  assign mem_write = at_wr;
  assign stall     = mem_valid && !mem_ready;
  assign rd_fire   = at_rd && mem_ready;
  assign idle      = (st_q == S_IDLE);
  assign res_valid = (st_q == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      lim_q <= '0;
      mem_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q  <= S_RUN;
          cnt_q <= '0;
          mem_q <= is_mem;
          wr_q  <= needs_wr;
          if (!is_mem)       lim_q <= CW'(LAT_REG - 2);
          else if (needs_wr) lim_q <= CW'(LAT_RMW - 2);
          else               lim_q <= CW'(LAT_MRD - 2);
        end
        S_RUN: if (!stall) begin
          if (cnt_q == lim_q) st_q <= S_DONE;
          else                cnt_q <= cnt_q + 1'b1;
        end
        default: if (res_ready) st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pfx_bitops.sv
module pfx_bitops
  import pfx_pkg::*;
#(
  parameter int MCYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [7:0]   op_code,
  output logic [2:0]   rf_sel,
  input  logic [DW-1:0] rf_rdata,
  input  logic [3:0]   flg_in,
  output logic         mem_valid,
  output logic         mem_write,
  output logic [DW-1:0] mem_wdata,
  input  logic         mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [DW-1:0] res_data,
  output logic [3:0]   res_flags,
  output logic         res_wb,
  output logic [2:0]   res_sel
);
  dec_t          dec_in;
  logic          mem_in;
  logic          wr_in;
  dec_t          dec_q;
  logic [DW-1:0] opnd_q;
  flags_t        flg_q;
  logic          idle;
  logic          rd_fire;
  logic          start;
  logic [DW-1:0] alu_res;
  flags_t        alu_flg;
  logic [1:0]    cls_q;

  pfx_decode u_dec (
    .code     (op_code),
    .dec      (dec_in),
    .is_mem   (mem_in),
    .needs_wr (wr_in)
  );

  assign op_ready = idle;
  assign start    = op_valid && idle;
  assign rf_sel   = op_code[2:0];

  pfx_seq #(.MCYC(MCYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_mem    (mem_in),
    .needs_wr  (wr_in),
    .mem_ready (mem_ready),
    .res_ready (res_ready),
    .idle      (idle),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .rd_fire   (rd_fire),
    .res_valid (res_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q  <= '0;
      opnd_q <= '0;
      flg_q  <= '0;
    end else if (start) begin
      dec_q  <= dec_in;
      opnd_q <= rf_rdata;
      flg_q  <= flags_t'(flg_in);
    end else if (rd_fire) begin
      opnd_q <= mem_rdata;
    end
  end

  pfx_alu #(.W(DW)) u_alu (
    .cls  (dec_q.cls),
    .sub  (dec_q.sub),
    .opnd (opnd_q),
    .fin  (flg_q),
    .res  (alu_res),
    .fout (alu_flg)
  );

  assign cls_q     = dec_q.cls;
  assign mem_wdata = alu_res;
  assign res_data  = alu_res;
  assign res_flags = alu_flg;
  assign res_sel   = dec_q.sel;
  assign res_wb    = (dec_q.sel != SEL_MEM) && (dec_q.cls != CLS_TEST);
endmodule

// File: rtl/pfx_bitops_chk.sv
module pfx_bitops_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_ready,
  input logic       res_valid,
  input logic       res_ready,
  input logic [7:0] res_data,
  input logic [3:0] res_flags,
  input logic       res_wb,
  input logic [2:0] res_sel,
  input logic       mem_valid,
  input logic       mem_write,
  input logic       mem_ready,
  input logic [1:0] cls_q
);
  // R11
  a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_flags));

  // R11
  a_r11_no_accept_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !op_ready);

  // R9
  a_r9_no_mem_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_wb |-> res_sel != 3'd6);

  // R4
  a_r4_shift_flags: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cls_q == 2'b00 |-> res_flags[3] == (res_data == 8'h00) && res_flags[2:1] == 2'b00);

  // R10
  a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_write |=> !(mem_valid && !mem_write));
endmodule

bind pfx_bitops pfx_bitops_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_ready  (op_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_flags (res_flags),
  .res_wb    (res_wb),
  .res_sel   (res_sel),
  .mem_valid (mem_valid),
  .mem_write (mem_write),
  .mem_ready (mem_ready),
  .cls_q     (cls_q)
);

// File: tb/pfx_bitops_test.sv
`timescale 1ns/1ps
module pfx_bitops_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [7:0] op_code = '0;
  logic [2:0] rf_sel;
  logic [7:0] rf_rdata = '0;
  logic [3:0] flg_in = '0;
  logic       mem_valid, mem_write;
  logic [7:0] mem_wdata;
  logic       mem_ready = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic       res_valid;
  logic       res_ready = 1'b0;
  logic [7:0] res_data;
  logic [3:0] res_flags;
  logic       res_wb;
  logic [2:0] res_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pfx_bitops uut (.*);

  // {op, operand, flags in, exp data, exp flags {Z,N,H,C}, exp wb}
  localparam logic [32:0] VEC [20] = '{
    {8'h00, 8'h85, 4'b0000, 8'h0B, 4'b0001, 1'b1},  // R3 rlc
    {8'h09, 8'h01, 4'b0000, 8'h80, 4'b0001, 1'b1},  // R3 rrc
    {8'h12, 8'h80, 4'b0001, 8'h01, 4'b0001, 1'b1},  // R5 rl carry in
    {8'h13, 8'h80, 4'b0000, 8'h00, 4'b1001, 1'b1},  // R4 zero
    {8'h1C, 8'h01, 4'b0001, 8'h80, 4'b0001, 1'b1},  // R5 rr carry in
    {8'h1F, 8'h02, 4'b1110, 8'h01, 4'b0000, 1'b1},  // R4 clears N,H
    {8'h25, 8'hC1, 4'b0000, 8'h82, 4'b0001, 1'b1},  // R3 sla
    {8'h28, 8'h81, 4'b0000, 8'hC0, 4'b0001, 1'b1},  // R5 sra keeps b7
    {8'h29, 8'h01, 4'b0000, 8'h00, 4'b1001, 1'b1},  // R5 sra to zero
    {8'h32, 8'hA5, 4'b0001, 8'h5A, 4'b0000, 1'b1},  // R6 swap
    {8'h37, 8'h00, 4'b0111, 8'h00, 4'b1000, 1'b1},  // R6 swap zero
    {8'h3B, 8'h81, 4'b0000, 8'h40, 4'b0001, 1'b1},  // R3 srl
    {8'h40, 8'hFE, 4'b0001, 8'hFE, 4'b1011, 1'b0},  // R7 bit0 clear
    {8'h7F, 8'h80, 4'b0000, 8'h80, 4'b0010, 1'b0},  // R7 bit7 set
    {8'h5C, 8'hF7, 4'b0100, 8'hF7, 4'b1010, 1'b0},  // R7 bit3
    {8'hBF, 8'hFF, 4'b0101, 8'h7F, 4'b0101, 1'b1},  // R8 clear 7
    {8'h81, 8'h01, 4'b1000, 8'h00, 4'b1000, 1'b1},  // R8 clear 0
    {8'hDA, 8'h00, 4'b0000, 8'h08, 4'b0000, 1'b1},  // R8 set 3
    {8'hF5, 8'h80, 4'b1111, 8'hC0, 4'b1111, 1'b1},  // R8 set 6
    {8'h07, 8'h00, 4'b0001, 8'h00, 4'b1000, 1'b1}   // R4 rlc zero
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] val, input logic [3:0] fin,
                        input logic [7:0] mval, input int rd_stall, input int wr_stall,
                        input int hold,
                        output logic [7:0] d, output logic [3:0] f, output logic wb,
                        output logic [2:0] sel, output int lat, output int nrd,
                        output int nwr, output logic [7:0] wdat);
    int rs = rd_stall;
    int ws = wr_stall;
    lat = 0; nrd = 0; nwr = 0; wdat = 8'h00;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; rf_rdata = val; flg_in = fin;
    #0.1;
    chk("R2 rf_sel", int'(rf_sel), int'(op[2:0]));
    chk("R11 op_ready idle", int'(op_ready), 1);
    @(posedge clk);
    forever begin
      @(negedge clk);
      op_valid = 1'b0;
      mem_ready = 1'b0;
      if (res_valid) break;
      if (mem_valid) begin
        if (mem_write) begin
          if (ws > 0) ws--;
          else begin mem_ready = 1'b1; nwr++; wdat = mem_wdata; end
        end else begin
          if (rs > 0) rs--;
          else begin mem_ready = 1'b1; mem_rdata = mval; nrd++; end
        end
      end
      @(posedge clk);
      lat++;
    end
    d = res_data; f = res_flags; wb = res_wb; sel = res_sel;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R11 valid held", int'(res_valid), 1);
      chk("R11 data held", int'(res_data), int'(d));
      chk("R11 op_ready low", int'(op_ready), 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R11 released", int'(res_valid), 0);
  endtask

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, wdat;
    logic [3:0] f;
    logic wb;
    logic [2:0] sel;
    int lat, nrd, nwr;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 op_ready", int'(op_ready), 1);
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 mem_valid", int'(mem_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 op_ready after release", int'(op_ready), 1);

    for (int k = 0; k < 20; k++) begin
      run_op(VEC[k][32:25], VEC[k][24:17], VEC[k][16:13], 8'h00, 0, 0, 0,
             d, f, wb, sel, lat, nrd, nwr, wdat);
      chk("R3 R5 R6 R8 data", int'(d), int'(VEC[k][12:5]));
      chk("R4 R7 R8 flags", int'(f), int'(VEC[k][4:1]));
      chk("R9 res_wb", int'(wb), int'(VEC[k][0]));
      chk("R2 res_sel", int'(sel), int'(VEC[k][26:25]) | (int'(VEC[k][27]) << 2));
      chk("R9 register latency", lat, 7);
      chk("R9 register no memory", nrd + nwr, 0);
    end

    // R9 memory shift: srl (mem) 0x03 -> 0x01, C=1
    run_op(8'h3E, 8'hEE, 4'b0000, 8'h03, 0, 0, 0, d, f, wb, sel, lat, nrd, nwr, wdat);
    chk("R9 rmw latency", lat, 15);
    chk("R9 rmw reads", nrd, 1);
    chk("R9 rmw writes", nwr, 1);
    chk("R9 rmw write data", int'(wdat), 8'h01);
    chk("R4 rmw flags", int'(f), 4'b0001);
    chk("R9 rmw no wb", int'(wb), 0);
    chk("R2 mem sel", int'(sel), 6);

    // R9 memory bit test: bit 2 of 0x04
    run_op(8'h56, 8'h00, 4'b0000, 8'h04, 0, 0, 0, d, f, wb, sel, lat, nrd, nwr, wdat);
    chk("R9 test latency", lat, 11);
    chk("R9 test no write", nwr, 0);
    chk("R9 test one read", nrd, 1);
    chk("R7 mem test flags", int'(f), 4'b0010);

    // R8 set 7 on memory 0x01
    run_op(8'hFE, 8'h00, 4'b1001, 8'h01, 0, 0, 0, d, f, wb, sel, lat, nrd, nwr, wdat);
    chk("R8 mem set write", int'(wdat), 8'h81);
    chk("R8 mem set flags", int'(f), 4'b1001);
    chk("R9 mem set latency", lat, 15);

    // R10 stalls: rl (mem) 0x7F with C=1 -> 0xFF, flags 0
    run_op(8'h16, 8'h00, 4'b0001, 8'h7F, 3, 2, 0, d, f, wb, sel, lat, nrd, nwr, wdat);
    chk("R10 stalled latency", lat, 20);
    chk("R10 stalled write", int'(wdat), 8'hFF);
    chk("R10 stalled flags", int'(f), 4'b0000);
    chk("R10 one read", nrd, 1);

    // R11 back-pressure on sra of 0xF0 -> 0xF8
    run_op(8'h2F, 8'hF0, 4'b0000, 8'h00, 0, 0, 4, d, f, wb, sel, lat, nrd, nwr, wdat);
    chk("R11 data after hold", int'(d), 8'hF8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule